// File: doc/BRIEF.md
# Decimal (4221) Carry-Save Reducer

This block adds several multi-digit decimal operands without propagating carries. Every digit is held in the redundant (4221) code: four bits with weights 4, 2, 2 and 1. Because these weights add up to nine, ordinary binary full adders can combine three such digits without any decimal correction. The result is two (4221) words, a sum word S and a carry word H. The reduced total is S + 2H. A later carry-propagate stage forms that final value and is not part of this block.

The reduction runs level by level. At each level, groups of three operands enter a row of bitwise full adders. The carry word of each row is doubled before the next level. The doubler recodes every digit into a restricted (5211) form and shifts the word left by one bit. The bit shifted out of a digit becomes a decimal carry into the next column. The last row leaves its carry word undoubled, and that word is H. Operands are widened by one zero column, so every decimal carry has a place to land.

The tree itself is combinational. The outputs are registered at the block edge together with a valid flag.

Top module: `dcsa_reducer`

## Requirements
- R1: While `rst_n` is low, `out_valid_o`, `sum_o` and `car_o` are all zero.
- R2: `out_valid_o` equals the value `in_valid_i` had at the previous rising clock edge.
- R3: When `out_valid_o` is high, decoding `sum_o` and `car_o` by their (4221) weights gives S + 2H equal to the sum of the operand values captured one cycle earlier. This holds for any of the redundant encodings of each input digit.
- R4: A cycle with `in_valid_i` low leaves `sum_o` and `car_o` unchanged.
- R5: Operand k occupies `ops_i[k*4N +: 4N]`, where N is `NUM_DIGITS`. Digit i of an operand occupies bits [4i+3:4i] of its slice and has decimal weight 10^i. Inside a digit, bits 3, 2, 1 and 0 carry weights 4, 2, 2 and 1. The outputs use the same digit and bit layout, with N+1 digits.
- R6: The extra top digit of `sum_o` has a value of at most 5, and that of `car_o` at most 2. No decimal carry leaves the top column. This holds even when every input digit is nine.
- R7: All-zero operands give all-zero bit vectors on `sum_o` and `car_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands on `ops_i` are to be reduced this cycle |
| ops_i | input | NUM_OPS*NUM_DIGITS*4 | Packed (4221) operands |
| out_valid_o | output | 1 | `sum_o` and `car_o` hold a fresh result |
| sum_o | output | (NUM_DIGITS+1)*4 | Sum word S in (4221) |
| car_o | output | (NUM_DIGITS+1)*4 | Carry word H in (4221), weight 2 |

## Verification
The bench generates each digit value and then picks a random (4221) bit pattern for it, so the redundant encodings (for example 0110 versus 1000 for four) all reach the full adders. A doubler with a wrong recode entry, or one that drops its shifted carry, would break S + 2H only for certain digit values, and random sweeps of those values expose it.

All-nines operands drive a carry out of every column and into the extra digit. A block that loses the top carry, or that sizes the output too narrowly, would report a total that is short by a multiple of a power of ten. Complement pairs (an operand next to its bitwise inverse) check that inversion yields the nines' complement.

Idle cycles check that outputs hold their values. A single nonzero digit placed at the lowest and at the highest position checks bit and digit ordering.

// File: rtl/dcsa_pkg.sv
package dcsa_pkg;

    // Decimal value of one (4221) digit.
    function automatic int dig_val(input logic [3:0] d);
        return 4 * int'(d[3]) + 2 * int'(d[2]) + 2 * int'(d[1]) + int'(d[0]);
    endfunction

    // Recode a (4221) digit into the restricted (5211) subset.
    // Shifting the result left by one bit yields 2v mod 10 in (4221),
    // and bit 3 of the result is the decimal carry.
    function automatic logic [3:0] to_5211s(input logic [3:0] d);
        int v;
        int r;
        logic hi;
        logic [2:0] lo;
        v  = dig_val(d);
        hi = (v >= 5);
        r  = hi ? v - 5 : v;
        case (r)
            0:       lo = 3'b000;
            1:       lo = 3'b001;
            2:       lo = 3'b011;
            3:       lo = 3'b101;
            default: lo = 3'b111;
        endcase
        return {hi, lo};
    endfunction

    // Operand count after one level of 3:2 rows.
    function automatic int next_cnt(input int c);
        return 2 * (c / 3) + (c % 3);
    endfunction

    // Operand count entering level lv.
    function automatic int cnt_at(input int p, input int lv);
        int c;
        c = p;
        for (int i = 0; i < lv; i++) c = next_cnt(c);
        return c;
    endfunction

    // Number of levels needed to reach two words.
    function automatic int n_levels(input int p);
        int c;
        int l;
        c = p;
        l = 0;
        while (c > 2 && l < 8) begin
            c = next_cnt(c);
            l++;
        end
        return l;
    endfunction

endpackage

// File: rtl/dcsa_row.sv
// Bitwise binary full adders over whole (4221) words: A + B + C = S + 2H per digit.
module dcsa_row #(
    parameter int WIDTH = 20
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    output logic [WIDTH-1:0] s_o,
    output logic [WIDTH-1:0] h_o
);
    assign s_o = a_i ^ b_i ^ c_i;
    assign h_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/dcsa_dbl.sv
// Word doubler: per-digit recode into (5211s), then a 1-bit left shift
// with the shifted-out bit passed up one decimal column.
module dcsa_dbl
    import dcsa_pkg::*;
#(
    parameter int DIGITS = 5
) (
    input  logic [DIGITS*4-1:0] x_i,
    output logic [DIGITS*4-1:0] y_o,
    output logic                spill_o
);
    logic [DIGITS-1:0] cy;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] w;
        assign w     = to_5211s(x_i[4*g +: 4]);
        assign cy[g] = w[3];
        if (g == 0) begin : g_lsd
            assign y_o[3:0] = {w[2:0], 1'b0};
        end else begin : g_upper
            assign y_o[4*g +: 4] = {w[2:0], cy[g-1]};
        end
    end

    assign spill_o = cy[DIGITS-1];
endmodule

// File: rtl/dcsa_tree.sv
// Level-by-level reduction of NUM_OPS operands down to S and H.
module dcsa_tree
    import dcsa_pkg::*;
#(
    parameter int NUM_OPS    = 5,
    parameter int NUM_DIGITS = 4
) (
    input  logic [NUM_OPS*NUM_DIGITS*4-1:0] ops_i,
    output logic [(NUM_DIGITS+1)*4-1:0]     sum_o,
    output logic [(NUM_DIGITS+1)*4-1:0]     car_o,
    output logic                            spill_o
);
    localparam int OPW  = NUM_DIGITS * 4;
    localparam int WD   = NUM_DIGITS + 1;
    localparam int WW   = WD * 4;
    localparam int NLEV = n_levels(NUM_OPS);

    logic [WW-1:0] stg [0:NLEV][0:NUM_OPS-1];
    logic [NLEV-1:0][NUM_OPS-1:0] spl;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_in
        assign stg[0][k] = {4'b0000, ops_i[k*OPW +: OPW]};
    end

    for (genvar lv = 0; lv < NLEV; lv++) begin : g_lvl
        localparam int C    = cnt_at(NUM_OPS, lv);
        localparam int NT   = C / 3;
        localparam int RM   = C % 3;
        localparam int NC   = next_cnt(C);
        localparam bit LAST = (C == 3);

        for (genvar t = 0; t < NT; t++) begin : g_row
            logic [WW-1:0] s;
            logic [WW-1:0] h;
            dcsa_row #(.WIDTH(WW)) u_row (
                .a_i(stg[lv][3*t]),
                .b_i(stg[lv][3*t+1]),
                .c_i(stg[lv][3*t+2]),
                .s_o(s),
                .h_o(h)
            );
            assign stg[lv+1][2*t] = s;
            if (LAST) begin : g_keep
                assign stg[lv+1][2*t+1] = h;
                assign spl[lv][t]       = 1'b0;
            end else begin : g_twice
                dcsa_dbl #(.DIGITS(WD)) u_dbl (
                    .x_i(h),
                    .y_o(stg[lv+1][2*t+1]),
                    .spill_o(spl[lv][t])
                );
            end
        end

        for (genvar r = 0; r < RM; r++) begin : g_pass
            assign stg[lv+1][2*NT+r] = stg[lv][3*NT+r];
        end

        for (genvar j = NC; j < NUM_OPS; j++) begin : g_zero
            assign stg[lv+1][j] = '0;
        end

        for (genvar t = NT; t < NUM_OPS; t++) begin : g_nospl
            assign spl[lv][t] = 1'b0;
        end
    end

    assign sum_o   = stg[NLEV][0];
    assign car_o   = stg[NLEV][1];
    assign spill_o = |spl;
endmodule

// File: rtl/dcsa_reducer.sv
// Top: registered decimal (4221) carry-save reducer.
module dcsa_reducer
    import dcsa_pkg::*;
#(
    parameter int NUM_OPS    = 5,
    parameter int NUM_DIGITS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid_i,
    input  logic [NUM_OPS*NUM_DIGITS*4-1:0] ops_i,
    output logic                            out_valid_o,
    output logic [(NUM_DIGITS+1)*4-1:0]     sum_o,
    output logic [(NUM_DIGITS+1)*4-1:0]     car_o
);
    localparam int INW  = NUM_OPS * NUM_DIGITS * 4;
    localparam int OUTW = (NUM_DIGITS + 1) * 4;

    logic [OUTW-1:0] t_sum;
    logic [OUTW-1:0] t_car;
    logic            t_spill;

    dcsa_tree #(.NUM_OPS(NUM_OPS), .NUM_DIGITS(NUM_DIGITS)) u_tree (
        .ops_i(ops_i),
        .sum_o(t_sum),
        .car_o(t_car),
        .spill_o(t_spill)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            sum_o       <= '0;
            car_o       <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                sum_o <= t_sum;
                car_o <= t_car;
            end
        end
    end

    function automatic longint word_val(input logic [OUTW-1:0] w);
        longint acc;
        acc = 0;
        for (int i = NUM_DIGITS; i >= 0; i--) acc = acc * 10 + longint'(dig_val(w[4*i +: 4]));
        return acc;
    endfunction

    function automatic longint in_total(input logic [INW-1:0] v);
        longint acc;
        longint op;
        acc = 0;
        for (int k = 0; k < NUM_OPS; k++) begin
            op = 0;
            for (int i = NUM_DIGITS - 1; i >= 0; i--)
                op = op * 10 + longint'(dig_val(v[k*NUM_DIGITS*4 + 4*i +: 4]));
            acc += op;
        end
        return acc;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (!out_valid_o && sum_o == '0 && car_o == '0)); // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid_i |=> out_valid_o); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid_i |=> !out_valid_o); // R2
    AST_TOTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (word_val(sum_o) + 2 * word_val(car_o) == $past(in_total(ops_i)))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(sum_o) && $stable(car_o))); // R4
    AST_NO_SPILL: assert property (@(posedge clk) disable iff (!rst_n) in_valid_i |-> !t_spill); // R6
    AST_TOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (dig_val(sum_o[OUTW-1 -: 4]) <= 5 && dig_val(car_o[OUTW-1 -: 4]) <= 2)); // R6
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && ops_i == '0) |=> (sum_o == '0 && car_o == '0)); // R7
endmodule

// File: tb/test_dcsa_reducer.sv
module test_dcsa_reducer;
    localparam int CLK_PERIOD = 10;
    localparam int NOPS = 5;
    localparam int ND   = 4;
    localparam int INW  = NOPS * ND * 4;
    localparam int OUTW = (ND + 1) * 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [INW-1:0]  ops;
    logic            out_valid;
    logic [OUTW-1:0] sum_w;
    logic [OUTW-1:0] car_w;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcsa_reducer #(.NUM_OPS(NOPS), .NUM_DIGITS(ND)) i_dcsa_reducer (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .ops_i(ops),
        .out_valid_o(out_valid), .sum_o(sum_w), .car_o(car_w)
    );

    function automatic int wt(input logic [3:0] d);
        return (d[3] ? 4 : 0) + (d[2] ? 2 : 0) + (d[1] ? 2 : 0) + (d[0] ? 1 : 0);
    endfunction

    function automatic longint out_val(input logic [OUTW-1:0] w);
        longint acc = 0;
        for (int i = ND; i >= 0; i--) acc = acc * 10 + wt(w[4*i +: 4]);
        return acc;
    endfunction

    function automatic longint ops_val(input logic [INW-1:0] v);
        longint acc = 0;
        longint p;
        for (int k = 0; k < NOPS; k++) begin
            p = 1;
            for (int i = 0; i < ND; i++) begin
                acc += p * wt(v[k*ND*4 + 4*i +: 4]);
                p *= 10;
            end
        end
        return acc;
    endfunction

    function automatic logic [3:0] rand_code(input int v);
        logic [3:0] b;
        b = 4'($urandom);
        while (wt(b) != v) b = 4'($urandom);
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycle-by-cycle reference: drive at a falling edge, compare at the next one.
    task automatic step(input bit v, input logic [INW-1:0] o, input string req);
        logic [OUTW-1:0] ps = sum_w;
        logic [OUTW-1:0] pc = car_w;
        longint exp_t = ops_val(o);
        longint got;
        in_valid = v;
        ops = o;
        @(negedge clk);
        check(out_valid == v, "R2 valid lag", longint'(out_valid), longint'(v));
        if (v) begin
            got = out_val(sum_w) + 2 * out_val(car_w);
            check(got == exp_t, req, got, exp_t);
            check(wt(sum_w[OUTW-1 -: 4]) <= 5 && wt(car_w[OUTW-1 -: 4]) <= 2, "R6 top digit bound",
                  longint'(wt(sum_w[OUTW-1 -: 4]) * 10 + wt(car_w[OUTW-1 -: 4])), 52);
        end else begin
            check(sum_w == ps && car_w == pc, "R4 hold when idle", out_val(sum_w), out_val(ps));
        end
    endtask

    initial begin
        logic [INW-1:0] o;
        rst_n = 1'b0;
        in_valid = 1'b0;
        ops = '0;
        repeat (3) @(negedge clk);
        check(!out_valid && sum_w == '0 && car_w == '0, "R1 reset state", out_val(sum_w), 0);
        rst_n = 1'b1;

        // R7 all-zero operands
        step(1'b1, '0, "R3 zero total");
        check(sum_w == '0 && car_w == '0, "R7 zero vectors", out_val(sum_w) + out_val(car_w), 0);

        // R5 layout: lowest digit of operand 0, weight-4 bit only
        o = '0; o[3] = 1'b1;
        step(1'b1, o, "R5 low digit layout");
        check(out_val(sum_w) + 2 * out_val(car_w) == 4, "R5 low digit value",
              out_val(sum_w) + 2 * out_val(car_w), 4);
        // R5 layout: top digit of last operand, weight-1 bit only
        o = '0; o[INW-4] = 1'b1;
        step(1'b1, o, "R5 high digit layout");
        check(out_val(sum_w) + 2 * out_val(car_w) == 1000, "R5 high digit value",
              out_val(sum_w) + 2 * out_val(car_w), 1000);

        // R6 all nines
        step(1'b1, {INW{1'b1}}, "R6 all nines");
        check(out_val(sum_w) + 2 * out_val(car_w) == NOPS * 9999, "R6 nines total",
              out_val(sum_w) + 2 * out_val(car_w), NOPS * 9999);

        // R4 idle cycles after a nonzero result
        step(1'b0, {INW{1'b1}}, "R4 idle");
        step(1'b0, '0, "R4 idle");

        // R3 complement pairs
        for (int n = 0; n < 20; n++) begin
            logic [ND*4-1:0] a;
            logic [ND*4-1:0] b;
            for (int i = 0; i < ND; i++) begin
                a[4*i +: 4] = rand_code($urandom_range(9));
                b[4*i +: 4] = rand_code($urandom_range(9));
            end
            o = '0;
            o[0 +: ND*4] = a;
            o[ND*4 +: ND*4] = ~a;
            o[2*ND*4 +: ND*4] = b;
            o[3*ND*4 +: ND*4] = ~b;
            step(1'b1, o, "R3 complement pairs");
        end

        // R3 random redundant encodings with random idle cycles
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < NOPS; k++)
                for (int i = 0; i < ND; i++) begin
                    int dv = ($urandom_range(3) == 0) ? 9 : int'($urandom_range(9));
                    o[k*ND*4 + 4*i +: 4] = rand_code(dv);
                end
            step($urandom_range(3) != 0, o, "R3 random redundant");
        end

        // R1 reset again clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid && sum_w == '0 && car_w == '0, "R1 reset clears", out_val(sum_w), 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule